// File: doc/BRIEF.md
# Streaming pairwise and running summer

This block watches a stream of unsigned samples, at most one per clock, each marked by a valid strobe. For every accepted sample it reports a sum built only from samples that arrived earlier; the sample on the input in that cycle never counts toward its own result. A mode input picks which sum is reported. In pair mode it is the sum of the two previous samples. In running mode it is the total of every sample accepted since reset or the last clear.

Both the two-deep sample history and the running total update on every accepted sample, whatever the mode. A mode change therefore gives a correct result on the very next accepted sample. A clear input restarts the stream without a full reset. The result for an accepted sample is presented combinationally in the same cycle as that sample. Between accepted samples the output holds the last reported value.

Top module: `stream_lag_summer`

## Requirements
- R1: After reset, samples that do not exist yet count as zero: the first accepted sample reports 0 and the second reports the value of the first.
- R2: With mode_i = 0 (pair mode), an accepted sample n reports sample n-1 plus sample n-2, computed to W+1 bits with no loss (255 + 255 gives 510 for W = 8).
- R3: With mode_i = 1 (running mode), an accepted sample n reports the total of samples 0 through n-1, taken modulo 2^ACC_W.
- R4: valid_o is high in exactly the cycles where valid_i is high, and sum_o in such a cycle does not depend on data_i of that cycle.
- R5: A cycle with valid_i low changes neither the history nor the total, and sum_o keeps the value it had, even if mode_i changes.
- R6: A cycle with clear_i high zeroes the history and the total. If valid_i is also high, that sample reports 0 and becomes the new sample 0. If valid_i is low, sum_o reads 0 from the next cycle on.
- R7: A change of mode_i applies to the next accepted sample, and the result is already the correct sum for the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Sample strobe |
| data_i | input | W | Unsigned sample |
| mode_i | input | 1 | 0 = pair sum, 1 = running total |
| clear_i | input | 1 | Synchronous restart of history and total |
| valid_o | output | 1 | Result strobe, same cycle as valid_i |
| sum_o | output | ACC_W | Sum of earlier samples, zero-extended in pair mode |

## Verification
A wrong value in either history register shows on sum_o at the next or the second-next accepted sample in pair mode. A wrong running total shows on the next accepted sample in running mode and stays wrong until a clear. Because both stores update in every mode, the bench toggles mode often. A fault hidden in the unselected store then appears as soon as the mode switches. Idle gaps with mode changes show any leak of the unselected path into the held output in the same cycle.

// File: rtl/lag_sum_pkg.sv
package lag_sum_pkg;
    typedef enum logic {
        MODE_PAIR = 1'b0,
        MODE_RUN  = 1'b1
    } sum_mode_e;
endpackage

// File: rtl/lag_sum_history.sv
module lag_sum_history #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] older_o,
    output logic [W-1:0] newer_o
);
    typedef struct packed {
        logic [W-1:0] older;
        logic [W-1:0] newer;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (clr_i) begin
            hist_d.older = '0;
            hist_d.newer = adv_i ? din_i : '0;
        end else if (adv_i) begin
            hist_d.older = hist_q.newer;
            hist_d.newer = din_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= '0;
        else       hist_q <= hist_d;
    end

    assign older_o = hist_q.older;
    assign newer_o = hist_q.newer;
endmodule

// File: rtl/lag_sum_accum.sv
module lag_sum_accum #(
    parameter int W     = 8,
    parameter int ACC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [W-1:0]     din_i,
    output logic [ACC_W-1:0] total_o
);
    typedef struct packed {
        logic [ACC_W-1:0] total;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [ACC_W-1:0] din_ext;

    assign din_ext = ACC_W'(din_i);

    always_comb begin
        acc_d = acc_q;
        if (clr_i)      acc_d.total = adv_i ? din_ext : '0;
        else if (adv_i) acc_d.total = acc_q.total + din_ext;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) acc_q <= '0;
        else       acc_q <= acc_d;
    end

    assign total_o = acc_q.total;
endmodule

// File: rtl/stream_lag_summer.sv
module stream_lag_summer #(
    parameter int W     = 8,
    parameter int ACC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             valid_i,
    input  logic [W-1:0]     data_i,
    input  logic             mode_i,
    input  logic             clear_i,
    output logic             valid_o,
    output logic [ACC_W-1:0] sum_o
);
    import lag_sum_pkg::*;

    localparam int PAIR_W = W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] held;
    } out_t;

    logic [W-1:0]      older_q;
    logic [W-1:0]      newer_q;
    logic [ACC_W-1:0]  acc_q;
    logic [PAIR_W-1:0] pair_sum;
    logic [ACC_W-1:0]  pair_ext;
    logic [ACC_W-1:0]  selected;
    sum_mode_e         mode_sel;
    out_t              out_d, out_q;

    lag_sum_history #(.W(W)) u_hist (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (clear_i),
        .adv_i   (valid_i),
        .din_i   (data_i),
        .older_o (older_q),
        .newer_o (newer_q)
    );

    lag_sum_accum #(.W(W), .ACC_W(ACC_W)) u_acc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (clear_i),
        .adv_i   (valid_i),
        .din_i   (data_i),
        .total_o (acc_q)
    );

    assign pair_sum = PAIR_W'(older_q) + PAIR_W'(newer_q);

    generate
        if (ACC_W > PAIR_W) begin : g_pad
            assign pair_ext = {{(ACC_W-PAIR_W){1'b0}}, pair_sum};
        end else begin : g_trunc
            assign pair_ext = pair_sum[ACC_W-1:0];
        end
    endgenerate

    assign mode_sel = sum_mode_e'(mode_i);

    always_comb begin
        out_d = out_q;
        if (clear_i)                   selected = '0;
        else if (mode_sel == MODE_RUN) selected = acc_q;
        else                           selected = pair_ext;
        if (valid_i)      out_d.held = selected;
        else if (clear_i) out_d.held = '0;
        sum_o   = valid_i ? selected : out_q.held;
        valid_o = valid_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) out_q <= '0;
        else       out_q <= out_d;
    end
endmodule

// File: rtl/lag_sum_chk.sv
module lag_sum_chk #(
    parameter int W     = 8,
    parameter int ACC_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             valid_i,
    input logic [W-1:0]     data_i,
    input logic             clear_i,
    input logic [ACC_W-1:0] sum_o,
    input logic [W-1:0]     older_i,
    input logic [W-1:0]     newer_i,
    input logic [ACC_W-1:0] acc_i
);
    // R1: the first cycle out of reset reports zero
    p_zero_start_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> sum_o == '0);

    // R2: an accepted sample shifts the two-deep history
    p_shift_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && !clear_i) |=> (newer_i == $past(data_i) && older_i == $past(newer_i)));

    // R3: an accepted sample adds into the total modulo 2^ACC_W
    p_accum_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && !clear_i) |=> acc_i == ACC_W'($past(acc_i) + ACC_W'($past(data_i))));

    // R5: idle cycles leave the output unchanged
    p_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!valid_i && !clear_i) |=> (valid_i || $stable(sum_o)));

    // R6: an idle clear empties both stores
    p_clear_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (clear_i && !valid_i) |=> (acc_i == '0 && older_i == '0 && newer_i == '0));
endmodule

bind stream_lag_summer lag_sum_chk #(.W(W), .ACC_W(ACC_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .valid_i (valid_i),
    .data_i  (data_i),
    .clear_i (clear_i),
    .sum_o   (sum_o),
    .older_i (older_q),
    .newer_i (newer_q),
    .acc_i   (acc_q)
);

// File: tb/sim_stream_lag_summer.sv
`timescale 1ns/1ps
module sim_stream_lag_summer;
    localparam int W     = 8;
    localparam int ACC_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             valid_i;
    logic [W-1:0]     data_i;
    logic             mode_i;
    logic             clear_i;
    logic             valid_o;
    logic [ACC_W-1:0] sum_o;

    int n_checks = 0;
    int n_fail   = 0;

    int      hist[$];
    longint  total    = 0;
    longint  last_out = 0;

    always #5 clk = ~clk;

    stream_lag_summer #(.W(W), .ACC_W(ACC_W)) u0 (
        .clk_i   (clk),
        .rst_i   (rst),
        .valid_i (valid_i),
        .data_i  (data_i),
        .mode_i  (mode_i),
        .clear_i (clear_i),
        .valid_o (valid_o),
        .sum_o   (sum_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive after the falling edge, compare, then let the rising edge act
    task automatic step(input string tag, input bit v, input int d, input bit m, input bit c);
        longint exp;
        @(negedge clk);
        valid_i = v; data_i = W'(d); mode_i = m; clear_i = c;
        #1;
        if (v) begin
            if (c)      exp = 0;
            else if (m) exp = total & ((64'd1 << ACC_W) - 1);
            else begin
                exp = 0;
                foreach (hist[i]) exp += hist[i];
            end
        end else begin
            exp = last_out;
        end
        check({tag, " valid"}, longint'(valid_o), longint'(v));
        check({tag, " sum"}, longint'(sum_o), exp);
        if (c) begin
            hist.delete();
            total = 0;
            last_out = 0;
        end
        if (v) begin
            hist.push_back(d);
            if (hist.size() > 2) void'(hist.pop_front());
            total += d;
            last_out = exp;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; valid_i = 1'b0; data_i = '0; mode_i = 1'b0; clear_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset sum", longint'(sum_o), 0);
        check("R1 reset valid", longint'(valid_o), 0);

        // R1 and R2: pair mode from a fresh start
        step("R1", 1, 10, 0, 0);
        step("R1", 1, 20, 0, 0);
        step("R2", 1, 30, 0, 0);
        step("R2", 1, 40, 0, 0);
        step("R2", 1, 255, 0, 0);
        step("R2", 1, 255, 0, 0);
        step("R2", 1, 7, 0, 0);

        // R5: idle with mode toggling holds the output
        step("R5", 0, 99, 1, 0);
        step("R5", 0, 42, 0, 0);
        step("R5", 0, 13, 1, 0);

        // R7: switch modes between accepted samples
        step("R7", 1, 5, 1, 0);
        step("R7", 1, 6, 0, 0);
        step("R7", 1, 8, 1, 0);

        // R6: idle clear, then clear with a sample
        step("R6", 0, 0, 1, 1);
        step("R6", 0, 0, 1, 0);
        step("R6", 1, 50, 0, 0);
        step("R6", 1, 60, 0, 0);
        step("R6", 1, 70, 1, 1);
        step("R6", 1, 1, 1, 0);
        step("R6", 1, 2, 0, 0);

        // R3: running total wraps
        for (int k = 0; k < 300; k++) step("R3", 1, 255, 1, 0);
        step("R3", 1, 0, 1, 0);

        // R4: mixed traffic
        for (int k = 0; k < 3000; k++) begin
            step("R4", ($urandom_range(0, 3) != 0), $urandom_range(0, 255),
                 $urandom_range(0, 1), ($urandom_range(0, 40) == 0));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule